// File: doc/BRIEF.md
# Interrupt Category Concentrator

The block gathers level interrupt requests from many I/O devices into one byte of category bits and drives a single interrupt line toward the CPU. The categories are first timer/peripheral group, second peripheral group, serial, Ethernet, DMA and non-maskable. Some categories are qualified by state: an external flag byte from the first peripheral group, two enable bytes for the second group, and two DMA status bytes. The enable and status bytes, an interrupt control byte and a sound-output control byte sit behind a byte-wide register port.

The CPU services the line through the control byte. Writing it with the acknowledge bit set stores only the acknowledge and force bits, and drops the line. Reading it while the stored acknowledge bit is set also drops the line. The drop lasts one cycle, and the line comes back if any category is still pending. All outputs are registered, so the category byte and the line show the sources and settings of the previous cycle.

Top module: `irq_concentrator`

## Requirements
- R1: After reset the category byte, every stored register and the interrupt line are all zero.
- R2: A timer-group source sets category bit 0 one cycle later, but only while the first-group flag byte is nonzero.
- R3: A second-group source sets bit 0 when the flag byte is nonzero. Otherwise it sets bit 1 when either second-group enable byte (address 4 or 5) is nonzero. If neither holds, it sets no bit.
- R4: Any serial source sets bit 2, and any Ethernet source sets bit 3.
- R5: A general DMA source sets bit 4 only while DMA status byte 0 (address 2) is nonzero. A sound/auxiliary DMA source sets bit 4 only while DMA status byte 1 (address 3) is nonzero.
- R6: A write to the sound-output control byte (address 6) stores the data there and also sets bit 1 of DMA status byte 1.
- R7: The NMI source sets bit 7 with no qualification. Bits 5 and 6 always read zero.
- R8: A write to the control byte (address 0) with bit 7 set stores only bits 7 and 6. A write with bit 7 clear stores the whole byte.
- R9: An acknowledge forces the line low in the following cycle. An acknowledge is a write to address 0 with data bit 7 set, or a read of address 0 while the stored bit 7 is set. After that one cycle the line follows the pending state again.
- R10: While control bit 6 is set, any active source drives the line high one cycle later, even when its category is gated off.
- R11: Outside an acknowledge, the line is high exactly when some category bit is pending or the R10 condition holds. The category byte reads at address 1, and writes there change nothing.
- R12: Read data is combinational from the address. Addresses 0 to 6 return the control byte, category byte, DMA status 0 and 1, the two second-group enables and the sound control byte. Address 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_src | input | N_TMR | Timer/first-group request levels |
| grp1_flags | input | 8 | Flag byte of the first peripheral group |
| slot_src | input | N_SLOT | Slot, SCSI and floppy request levels |
| ser_src | input | N_SER | Serial channel request levels |
| eth_src | input | N_ETH | Ethernet controller/MAC request levels |
| dma_gen_src | input | N_DMA_GEN | General DMA channel request levels |
| dma_aux_src | input | N_DMA_AUX | Sound/auxiliary DMA request levels |
| nmi_src | input | 1 | Non-maskable request level |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| pending_o | output | 8 | Registered category byte |
| irq_o | output | 1 | CPU interrupt line |

## Verification
The folding is tried with single sources raised one group at a time, with each gating byte both zero and nonzero. This separates a missing gate from a wrong bit position. Second-group sources are driven with the flag byte set and clear, which shows whether the priority between the two groups holds. Acknowledges are issued as writes and as reads, with sources held active and with them quiet, which tells apart a one-cycle drop from a lasting clear. A long mixed phase of random sources and register traffic, including writes to the read-only address, is compared against the reference model on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int BYTE_W = 8;

   // register addresses
   localparam int A_CTRL    = 0;
   localparam int A_PEND    = 1;
   localparam int A_DMA0    = 2;
   localparam int A_DMA1    = 3;
   localparam int A_SLOT_EN = 4;
   localparam int A_GRP2_EN = 5;
   localparam int A_SND     = 6;

   // category bit positions
   localparam int C_GRP1 = 0;
   localparam int C_GRP2 = 1;
   localparam int C_SER  = 2;
   localparam int C_ETH  = 3;
   localparam int C_DMA  = 4;
   localparam int C_NMI  = 7;

   // control byte bits
   localparam int K_ACK   = 7;
   localparam int K_FORCE = 6;
   localparam logic [BYTE_W-1:0] K_ACK_KEEP = 8'hC0;
   localparam int SND_FLAG_BIT = 1;

   typedef struct packed {
      logic [BYTE_W-1:0] ctrl;
      logic [BYTE_W-1:0] dma0;
      logic [BYTE_W-1:0] dma1;
      logic [BYTE_W-1:0] slot_en;
      logic [BYTE_W-1:0] grp2_en;
      logic [BYTE_W-1:0] snd;
   } irqc_regs_t;
endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
   import irqc_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] pending,
   output logic [BYTE_W-1:0] rdata,
   output irqc_regs_t        regs,
   output logic              ack
);
   localparam int NREG = 1 << ADDR_W;

   irqc_regs_t r_q;
   logic       sel_ctrl;

   assign sel_ctrl = (addr == ADDR_W'(A_CTRL));
   assign ack = (wr && sel_ctrl && wdata[K_ACK]) ||
                (rd && sel_ctrl && r_q.ctrl[K_ACK]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
      end else if (wr) begin
         if (addr == ADDR_W'(A_CTRL))
            r_q.ctrl <= wdata[K_ACK] ? (wdata & K_ACK_KEEP) : wdata;
         if (addr == ADDR_W'(A_DMA0))
            r_q.dma0 <= wdata;
         if (addr == ADDR_W'(A_DMA1))
            r_q.dma1 <= wdata;
         if (addr == ADDR_W'(A_SLOT_EN))
            r_q.slot_en <= wdata;
         if (addr == ADDR_W'(A_GRP2_EN))
            r_q.grp2_en <= wdata;
         if (addr == ADDR_W'(A_SND)) begin
            r_q.snd <= wdata;
            r_q.dma1[SND_FLAG_BIT] <= 1'b1;
         end
      end
   end

   // read view as an array built per address
   logic [BYTE_W-1:0] view [NREG];
   for (genvar a = 0; a < NREG; a++) begin : g_view
      if (a == A_CTRL) begin : g_c
         assign view[a] = r_q.ctrl;
      end else if (a == A_PEND) begin : g_p
         assign view[a] = pending;
      end else if (a == A_DMA0) begin : g_d0
         assign view[a] = r_q.dma0;
      end else if (a == A_DMA1) begin : g_d1
         assign view[a] = r_q.dma1;
      end else if (a == A_SLOT_EN) begin : g_se
         assign view[a] = r_q.slot_en;
      end else if (a == A_GRP2_EN) begin : g_ge
         assign view[a] = r_q.grp2_en;
      end else if (a == A_SND) begin : g_s
         assign view[a] = r_q.snd;
      end else begin : g_z
         assign view[a] = '0;
      end
   end

   assign rdata = view[addr];
   assign regs  = r_q;
endmodule

// File: rtl/irqc_fold.sv
module irqc_fold
   import irqc_pkg::*;
#(
   parameter int N_TMR     = 4,
   parameter int N_SLOT    = 7,
   parameter int N_SER     = 2,
   parameter int N_ETH     = 2,
   parameter int N_DMA_GEN = 10,
   parameter int N_DMA_AUX = 3
) (
   input  logic [N_TMR-1:0]     tmr_src,
   input  logic [BYTE_W-1:0]    grp1_flags,
   input  logic [N_SLOT-1:0]    slot_src,
   input  logic [N_SER-1:0]     ser_src,
   input  logic [N_ETH-1:0]     eth_src,
   input  logic [N_DMA_GEN-1:0] dma_gen_src,
   input  logic [N_DMA_AUX-1:0] dma_aux_src,
   input  logic                 nmi_src,
   input  irqc_regs_t           regs,
   output logic [BYTE_W-1:0]    cat_next,
   output logic                 any_raw
);
   logic grp1_live, grp2_gate, dma0_gate, dma1_gate;
   logic tmr_any, slot_any, ser_any, eth_any, dg_any, da_any;

   assign grp1_live = |grp1_flags;
   assign grp2_gate = (|regs.slot_en) || (|regs.grp2_en);
   assign dma0_gate = |regs.dma0;
   assign dma1_gate = |regs.dma1;

   assign tmr_any  = |tmr_src;
   assign slot_any = |slot_src;
   assign ser_any  = |ser_src;
   assign eth_any  = |eth_src;
   assign dg_any   = |dma_gen_src;
   assign da_any   = |dma_aux_src;

   logic [BYTE_W-1:0] hit;
   always_comb begin
      hit         = '0;
      hit[C_GRP1] = (tmr_any || slot_any) && grp1_live;
      hit[C_GRP2] = slot_any && !grp1_live && grp2_gate;
      hit[C_SER]  = ser_any;
      hit[C_ETH]  = eth_any;
      hit[C_DMA]  = (dg_any && dma0_gate) || (da_any && dma1_gate);
      hit[C_NMI]  = nmi_src;
   end

   // only defined category positions pass; the rest are tied low
   for (genvar b = 0; b < BYTE_W; b++) begin : g_cat
      if (b == C_GRP1 || b == C_GRP2 || b == C_SER ||
          b == C_ETH  || b == C_DMA  || b == C_NMI) begin : g_used
         assign cat_next[b] = hit[b];
      end else begin : g_unused
         assign cat_next[b] = 1'b0;
      end
   end

   assign any_raw = tmr_any || slot_any || ser_any || eth_any ||
                    dg_any || da_any || nmi_src;
endmodule

// File: rtl/irqc_line.sv
module irqc_line
   import irqc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cat_next,
   input  logic              any_raw,
   input  logic              force_en,
   input  logic              ack,
   output logic [BYTE_W-1:0] pending_q,
   output logic              irq_q
);
   logic confirm;
   assign confirm = (|cat_next) || (force_en && any_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         irq_q     <= 1'b0;
      end else begin
         pending_q <= cat_next;
         irq_q     <= confirm && !ack;
      end
   end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
   import irqc_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int N_TMR     = 4,
   parameter int N_SLOT    = 7,
   parameter int N_SER     = 2,
   parameter int N_ETH     = 2,
   parameter int N_DMA_GEN = 10,
   parameter int N_DMA_AUX = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_TMR-1:0]     tmr_src,
   input  logic [7:0]           grp1_flags,
   input  logic [N_SLOT-1:0]    slot_src,
   input  logic [N_SER-1:0]     ser_src,
   input  logic [N_ETH-1:0]     eth_src,
   input  logic [N_DMA_GEN-1:0] dma_gen_src,
   input  logic [N_DMA_AUX-1:0] dma_aux_src,
   input  logic                 nmi_src,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   output logic [7:0]           pending_o,
   output logic                 irq_o
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must hold addresses 0..6");
   end
   if (N_TMR < 1 || N_SLOT < 1 || N_SER < 1 || N_ETH < 1 ||
       N_DMA_GEN < 1 || N_DMA_AUX < 1) begin : g_bad_src
      $error("every source group needs at least one input");
   end

   irqc_regs_t        regs;
   logic              ack;
   logic [BYTE_W-1:0] cat_next;
   logic              any_raw;
   logic [BYTE_W-1:0] ctrl_q, dma1_q;

   assign ctrl_q = regs.ctrl;
   assign dma1_q = regs.dma1;

   irqc_regfile #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
      .wdata(reg_wdata), .pending(pending_o), .rdata(reg_rdata),
      .regs(regs), .ack(ack)
   );

   irqc_fold #(
      .N_TMR(N_TMR), .N_SLOT(N_SLOT), .N_SER(N_SER), .N_ETH(N_ETH),
      .N_DMA_GEN(N_DMA_GEN), .N_DMA_AUX(N_DMA_AUX)
   ) u_fold (
      .tmr_src(tmr_src), .grp1_flags(grp1_flags), .slot_src(slot_src),
      .ser_src(ser_src), .eth_src(eth_src), .dma_gen_src(dma_gen_src),
      .dma_aux_src(dma_aux_src), .nmi_src(nmi_src), .regs(regs),
      .cat_next(cat_next), .any_raw(any_raw)
   );

   irqc_line u_line (
      .clk(clk), .rst_n(rst_n), .cat_next(cat_next), .any_raw(any_raw),
      .force_en(regs.ctrl[K_FORCE]), .ack(ack),
      .pending_q(pending_o), .irq_q(irq_o)
   );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int ADDR_W = 3,
   parameter int N_SER  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SER-1:0]  ser_src,
   input logic              nmi_src,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        pending_o,
   input logic              irq_o,
   input logic [7:0]        ctrl_q,
   input logic [7:0]        dma1_q
);
   logic wr_ack;
   assign wr_ack = reg_wr && (reg_addr == ADDR_W'(0)) && reg_wdata[7];

   // R9
   a_r9_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !irq_o);
   // R7
   a_r7_nmi_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_src |=> pending_o[7]);
   // R7
   a_r7_spare_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o[6:5] == 2'b00);
   // R4
   a_r4_serial_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (|ser_src) |=> pending_o[2]);
   // R6
   a_r6_sound_flags_dma1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(6)) |=> dma1_q[1]);
   // R8
   a_r8_ack_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> (ctrl_q[5:0] == 6'd0 && ctrl_q[7]));
   // R11
   a_r11_pending_raises_line: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !reg_rd) |=> ((pending_o != 8'd0) |-> irq_o));
endmodule

bind irq_concentrator irqc_checker #(.ADDR_W(ADDR_W), .N_SER(N_SER)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_src(ser_src), .nmi_src(nmi_src),
   .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_wdata(reg_wdata), .pending_o(pending_o), .irq_o(irq_o),
   .ctrl_q(ctrl_q), .dma1_q(dma1_q)
);

// File: tb/irq_concentrator_tb.sv
module irq_concentrator_tb;
   localparam int PERIOD = 10;
   localparam int AW = 3;
   localparam int NT = 4, NS = 7, NR = 2, NE = 2, NG = 10, NA = 3;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NT-1:0] tmr_src = '0;
   logic [7:0]    grp1_flags = '0;
   logic [NS-1:0] slot_src = '0;
   logic [NR-1:0] ser_src = '0;
   logic [NE-1:0] eth_src = '0;
   logic [NG-1:0] dma_gen_src = '0;
   logic [NA-1:0] dma_aux_src = '0;
   logic          nmi_src = 0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 0, reg_rd = 0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata, pending_o;
   logic          irq_o;

   int n_cmp = 0, n_bad = 0;
   string tag = "R1";
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   irq_concentrator u_dut (
      .clk(clk), .rst_n(rst_n), .tmr_src(tmr_src), .grp1_flags(grp1_flags),
      .slot_src(slot_src), .ser_src(ser_src), .eth_src(eth_src),
      .dma_gen_src(dma_gen_src), .dma_aux_src(dma_aux_src), .nmi_src(nmi_src),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pending_o(pending_o),
      .irq_o(irq_o)
   );

   // behavioural reference model
   int m_reg [7];
   int m_pend, m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 7; i++) m_reg[i] = 0;
         m_pend = 0; m_irq = 0;
      end else begin
         int np;
         bit ackn, raw;
         np = 0;
         if ((tmr_src != 0 || slot_src != 0) && grp1_flags != 0) np += 1;
         if (slot_src != 0 && grp1_flags == 0 && (m_reg[4] != 0 || m_reg[5] != 0)) np += 2;
         if (ser_src != 0) np += 4;
         if (eth_src != 0) np += 8;
         if ((dma_gen_src != 0 && m_reg[2] != 0) || (dma_aux_src != 0 && m_reg[3] != 0)) np += 16;
         if (nmi_src) np += 128;
         raw = (tmr_src != 0) || (slot_src != 0) || (ser_src != 0) || (eth_src != 0) ||
               (dma_gen_src != 0) || (dma_aux_src != 0) || nmi_src;
         ackn = (reg_wr && reg_addr == 0 && reg_wdata >= 128) ||
                (reg_rd && reg_addr == 0 && m_reg[0] >= 128);
         m_irq = (!ackn && (np != 0 || (((m_reg[0] / 64) % 2 == 1) && raw))) ? 1 : 0;
         if (reg_wr) begin
            int a, d;
            a = int'(reg_addr); d = int'(reg_wdata);
            if (a == 0) m_reg[0] = (d >= 128) ? (d / 64) * 64 : d;
            else if (a == 6) begin
               m_reg[6] = d;
               if ((m_reg[3] / 2) % 2 == 0) m_reg[3] += 2;
            end else if (a >= 2 && a <= 5) m_reg[a] = d;
         end
         m_pend = np;
      end
   end

   function automatic int exp_rdata(int a);
      if (a == 1) return m_pend;
      if (a == 7) return 0;
      return m_reg[a];
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "pending", int'(pending_o), m_pend);
         check(tag, "irq", int'(irq_o), m_irq);
         check("R12", "rdata", int'(reg_rdata), exp_rdata(int'(reg_addr)));
      end
   end

   task automatic idle();
      @(negedge clk); #1;
      reg_wr = 0; reg_rd = 0;
   endtask
   task automatic wr(int a, int d);
      @(negedge clk); #1;
      reg_addr = AW'(a); reg_wdata = 8'(d); reg_wr = 1; reg_rd = 0;
      @(negedge clk); #1;
      reg_wr = 0;
   endtask
   task automatic rd(int a);
      @(negedge clk); #1;
      reg_addr = AW'(a); reg_rd = 1; reg_wr = 0;
      @(negedge clk); #1;
      reg_rd = 0;
   endtask
   task automatic quiet();
      @(negedge clk); #1;
      tmr_src = '0; slot_src = '0; ser_src = '0; eth_src = '0;
      dma_gen_src = '0; dma_aux_src = '0; nmi_src = 0; grp1_flags = '0;
   endtask
   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_n(3);
      #1 rst_n = 1;
      // R1: reset state seen at the ports
      @(negedge clk);
      check("R1", "pending after reset", int'(pending_o), 0);
      check("R1", "irq after reset", int'(irq_o), 0);
      for (int a = 0; a < 8; a++) begin
         reg_addr = AW'(a); #1;
         check("R1", "register after reset", int'(reg_rdata), 0);
      end

      tag = "R2";
      @(negedge clk); #1 tmr_src = 4'b0100;
      wait_n(3);
      check("R2", "timer gated off", int'(pending_o), 0);
      #1 grp1_flags = 8'h20;
      wait_n(2);
      check("R2", "timer with flags", int'(pending_o), 1);
      quiet(); wait_n(2);

      tag = "R3";
      @(negedge clk); #1 slot_src = 7'b0010000;
      wait_n(2);
      check("R3", "slot no enables", int'(pending_o), 0);
      wr(5, 8'h01); wait_n(2);
      check("R3", "slot via enable", int'(pending_o), 2);
      wr(5, 0); wr(4, 8'h80); wait_n(2);
      check("R3", "slot via slot enable", int'(pending_o), 2);
      #1 grp1_flags = 8'h01;
      wait_n(2);
      check("R3", "group1 priority", int'(pending_o), 1);
      quiet(); wr(4, 0); wait_n(2);

      tag = "R4";
      @(negedge clk); #1 ser_src = 2'b10;
      wait_n(2);
      check("R4", "serial", int'(pending_o), 4);
      #1 ser_src = 0; eth_src = 2'b01;
      wait_n(2);
      check("R4", "ethernet", int'(pending_o), 8);
      quiet(); wait_n(2);

      tag = "R5";
      @(negedge clk); #1 dma_gen_src = 10'h200; dma_aux_src = 3'b001;
      wait_n(2);
      check("R5", "dma both gated", int'(pending_o), 0);
      wr(2, 8'h10); wait_n(2);
      check("R5", "general dma open", int'(pending_o), 16);
      wr(2, 0); wait_n(2);
      check("R5", "general closed again", int'(pending_o), 0);

      tag = "R6";
      wr(6, 8'h5A); wait_n(2);
      check("R6", "aux dma via sound write", int'(pending_o), 16);
      rd(3);
      check("R6", "dma1 flag set", m_reg[3], 2);
      quiet(); wait_n(2);

      tag = "R7";
      @(negedge clk); #1 nmi_src = 1;
      wait_n(2);
      check("R7", "nmi", int'(pending_o), 128);
      quiet(); wait_n(2);

      tag = "R8";
      wr(0, 8'h3F); wait_n(1);
      reg_addr = 0; #1;
      check("R8", "ctrl plain write", int'(reg_rdata), 8'h3F);
      wr(0, 8'hFF); wait_n(1);
      reg_addr = 0; #1;
      check("R8", "ctrl ack write masks", int'(reg_rdata), 8'hC0);

      tag = "R9";
      @(negedge clk); #1 eth_src = 2'b11;
      wait_n(3);
      check("R9", "line up before ack", int'(irq_o), 1);
      rd(0);
      check("R9", "line low after read ack", int'(irq_o), 0);
      wait_n(1);
      check("R9", "line back after one cycle", int'(irq_o), 1);
      wr(0, 8'h80);
      check("R9", "line low after write ack", int'(irq_o), 0);
      quiet(); wait_n(2);

      tag = "R10";
      wr(0, 8'h40);
      @(negedge clk); #1 dma_gen_src = 10'h001;
      wait_n(2);
      check("R10", "forced line", int'(irq_o), 1);
      check("R10", "no category", int'(pending_o), 0);
      wr(0, 8'h00); wait_n(2);
      check("R10", "unforced line", int'(irq_o), 0);
      quiet(); wait_n(2);

      tag = "R11";
      wr(1, 8'hFF); wait_n(1);
      reg_addr = 1; #1;
      check("R11", "pending not writable", int'(reg_rdata), 0);

      // mixed random traffic
      tag = "R11";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk); #1;
         tmr_src = NT'($urandom_range(0, 3) == 0 ? $urandom : 0);
         slot_src = NS'($urandom_range(0, 3) == 0 ? $urandom : 0);
         ser_src = NR'($urandom_range(0, 4) == 0 ? $urandom : 0);
         eth_src = NE'($urandom_range(0, 4) == 0 ? $urandom : 0);
         dma_gen_src = NG'($urandom_range(0, 3) == 0 ? $urandom : 0);
         dma_aux_src = NA'($urandom_range(0, 3) == 0 ? $urandom : 0);
         nmi_src = ($urandom_range(0, 15) == 0);
         grp1_flags = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom);
         reg_addr = AW'($urandom);
         reg_wdata = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
         case ($urandom_range(0, 5))
            0: begin reg_wr = 1; reg_rd = 0; end
            1: begin reg_wr = 0; reg_rd = 1; end
            default: begin reg_wr = 0; reg_rd = 0; end
         endcase
      end
      idle();
      wait_n(2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule